// File: doc/BRIEF.md
# Lowest-Set-Bit Mask Unit

This unit is a single-stage bit-manipulation execution block for a 64-bit integer datapath. It takes one issued operation and returns one registered result. The operation carries a value operand, an optional mask operand and a 5-bit mode. The mode picks three things: a plain or inverted copy of the value, one arithmetic neighbour of the value, and a bitwise operation that merges the two. Different modes produce the usual lowest-set-bit idioms. Examples are clearing the lowest set bit (`A & (A-1)`), isolating it (`A & -A`), filling the bits below it (`~A & (A-1)`), and a mask up to and including it (`A ^ (A-1)`).

The mask operand is applied before anything else. A zero mask leaves the value untouched. A nonzero mask is ANDed into the value, and both merged terms are then built from that masked value. Issue uses a valid/ready pair. Ready rises on the first clock after reset and then stays high, so the unit accepts one operation per cycle. The result register loads on each accepted issue. The result valid flag is high for exactly the cycle after the issue. The result register keeps its value until the next accepted issue.

Top module: `lsb_mask_unit`

## Requirements
- R1: Mode bits [4:3] choose how the two terms are merged: 0 = OR, 1 = AND, 2 = XOR, 3 = the result is forced to all zeros.
- R2: Mode bits [2:1] choose the second term, formed from the masked value A: 0 = -A (two's complement), 1 = A-1, 2 = A+1, 3 = ~(A+1).
- R3: Mode bit [0] chooses the first term: 1 = A, 0 = ~A. The second term is always formed from A, never from the inverted copy.
- R4: The masked value A equals `in_ra` when `in_rb` is zero, and equals `in_ra & in_rb` otherwise. This holds even when the AND leaves A at zero.
- R5: All arithmetic is modulo 2^64. When A is 0, A-1 is all ones. When A is all ones, A+1 is 0. When A is 0, -A is 0.
- R6: An issue is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `out_result` then shows the result of that issue after the edge, and `out_valid` is high for that one cycle.
- R7: With no accepted issue at an edge, `out_valid` is low after the edge and `out_result` keeps its value.
- R8: During reset, `out_valid`, `out_result` and `in_ready` are all zero. After reset is released, `in_ready` goes high at the first edge and never drops again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered this cycle |
| in_ready | output | 1 | The unit can accept an operation |
| in_mode | input | 5 | Merge operation [4:3], neighbour select [2:1], first-term polarity [0] |
| in_ra | input | 64 | Value operand |
| in_rb | input | 64 | Mask operand; zero means no mask |
| out_valid | output | 1 | High for the one cycle after an accepted issue |
| out_result | output | 64 | Registered result of the last accepted issue |

## Verification
The clocked properties assume that `in_valid` is never unknown after reset. The combinational checks in the operand and merge logic assume that `in_mode`, `in_ra` and `in_rb` hold known values whenever they are evaluated. The bench therefore sets every input to a defined value at time zero, before reset is released. It changes inputs only in the middle of a clock cycle, far from the sampling edge. Operand values are always fully specified, either from the directed table or from 32-bit random draws concatenated to 64 bits. This keeps every assertion's premise intact across the mode sweep and the wrap-around corner cases.

// File: rtl/lsbm_pkg.sv
package lsbm_pkg;

    parameter int unsigned MODE_W = 5;

    // merge operation, mode bits [4:3]
    typedef enum logic [1:0] {
        OP_OR   = 2'd0,
        OP_AND  = 2'd1,
        OP_XOR  = 2'd2,
        OP_ZERO = 2'd3
    } comb_op_e;

    // arithmetic neighbour of the masked value, mode bits [2:1]
    typedef enum logic [1:0] {
        NB_NEG  = 2'd0,
        NB_DEC  = 2'd1,
        NB_INC  = 2'd2,
        NB_NINC = 2'd3
    } neigh_e;

    // field layout of the mode word, MSB first
    typedef struct packed {
        comb_op_e op;
        neigh_e   nb;
        logic     first_true;
    } mode_t;

endpackage

// File: rtl/lsbm_operand.sv
module lsbm_operand
    import lsbm_pkg::*;
#(
    parameter int unsigned W            = 64,
    parameter bit          SHARED_ADDER = 1'b1
) (
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  neigh_e       nb,
    input  logic         first_true,
    output logic [W-1:0] first_op,
    output logic [W-1:0] second_op
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] base_a;

    // optional pre-mask: zero mask means pass through
    assign base_a   = (rb == '0) ? ra : (ra & rb);
    assign first_op = first_true ? base_a : ~base_a;

    generate
        if (SHARED_ADDER) begin : g_shared
            // one carry chain: -A = ~A + 1, A-1 = A + ones, A+1, ~(A+1)
            logic [W-1:0] add_base_d;
            logic [W-1:0] add_term_d;
            logic [W-1:0] add_sum_d;
            always_comb begin
                add_base_d = (nb == NB_NEG) ? ~base_a : base_a;
                add_term_d = (nb == NB_DEC) ? ONES : ONE;
                add_sum_d  = add_base_d + add_term_d;
                second_op  = (nb == NB_NINC) ? ~add_sum_d : add_sum_d;
            end
        end else begin : g_parallel
            // four independent results, selected at the end
            logic [W-1:0] neg_d;
            logic [W-1:0] dec_d;
            logic [W-1:0] inc_d;
            always_comb begin
                neg_d = ONE + ~base_a;
                dec_d = base_a - ONE;
                inc_d = base_a + ONE;
                unique case (nb)
                    NB_NEG:  second_op = neg_d;
                    NB_DEC:  second_op = dec_d;
                    NB_INC:  second_op = inc_d;
                    default: second_op = ~inc_d;
                endcase
            end
        end
    endgenerate

    // checks next to the operand logic
    always_comb begin
        // R3: the first term is A or its exact complement
        p_first_form_r3: assert (((first_op ^ base_a) == '0) || ((first_op ^ base_a) == ONES));
        // R4: the masked value never carries a bit absent from in_ra
        p_mask_subset_r4: assert ((base_a & ~ra) == '0);
        // R2 / R5: the neighbour relation holds modulo 2^W
        unique case (nb)
            NB_NEG:  p_nb_neg_r2:  assert (W'(second_op + base_a) == '0);
            NB_DEC:  p_nb_dec_r2:  assert (W'(second_op + ONE) == base_a);
            NB_INC:  p_nb_inc_r2:  assert (W'(second_op - ONE) == base_a);
            default: p_nb_ninc_r2: assert (W'(~second_op - ONE) == base_a);
        endcase
    end

endmodule

// File: rtl/lsbm_combine.sv
module lsbm_combine
    import lsbm_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  comb_op_e     op,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

    // R1: each merge keeps the bit relations its operation implies
    always_comb begin
        if (op == OP_AND) begin
            p_and_subset_r1: assert (((res & ~a) == '0) && ((res & ~b) == '0));
        end
        if (op == OP_OR) begin
            p_or_cover_r1: assert (((a & ~res) == '0) && ((b & ~res) == '0));
        end
        if (op == OP_XOR) begin
            p_xor_invert_r1: assert ((res ^ b) == a);
        end
    end

endmodule

// File: rtl/lsb_mask_unit.sv
module lsb_mask_unit
    import lsbm_pkg::*;
#(
    parameter int unsigned W            = 64,
    parameter bit          SHARED_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [MODE_W-1:0] in_mode,
    input  logic [W-1:0]      in_ra,
    input  logic [W-1:0]      in_rb,
    output logic              out_valid,
    output logic [W-1:0]      out_result
);

    typedef struct packed {
        logic         ready;
        logic         valid;
        logic [W-1:0] result;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    mode_t        mode;
    logic [W-1:0] first_op;
    logic [W-1:0] second_op;
    logic [W-1:0] comb_res;
    logic         issue;

    assign mode  = mode_t'(in_mode);
    assign issue = in_valid && st_q.ready;

    lsbm_operand #(
        .W            (W),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_operand (
        .ra         (in_ra),
        .rb         (in_rb),
        .nb         (mode.nb),
        .first_true (mode.first_true),
        .first_op   (first_op),
        .second_op  (second_op)
    );

    lsbm_combine #(
        .W (W)
    ) u_combine (
        .a   (first_op),
        .b   (second_op),
        .op  (mode.op),
        .res (comb_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.valid = issue;
        if (issue) begin
            st_d.result = comb_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = st_q.ready;
    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;

    // R6: an accepted issue produces a valid result on the next cycle
    p_valid_follows_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7: with no accepted issue, valid drops and the result holds
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
    p_result_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_result));

    // R1: the zero merge yields an all-zero result
    p_zero_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_mode[4:3] == 2'b11)) |=> (out_result == '0));

    // R8: once raised, ready never drops
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

endmodule

// File: tb/lsb_mask_unit_test.sv
`timescale 1ns/1ps
module lsb_mask_unit_test;

    typedef struct packed {
        logic [4:0]  mode;
        logic [63:0] ra;
        logic [63:0] rb;
        logic [63:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam vec_t VECS [NVEC] = '{
        '{5'd3,  64'h94, 64'h0,  64'h97},              // R1 OR,  A|(A-1)
        '{5'd11, 64'h94, 64'h0,  64'h90},              // R1 AND, A&(A-1)
        '{5'd19, 64'h94, 64'h0,  64'h07},              // R1 XOR, A^(A-1)
        '{5'd27, 64'h94, 64'h0,  64'h00},              // R1 zero
        '{5'd3,  64'h94, 64'hC3, 64'hFF},              // R4 masked A=0x80
        '{5'd9,  64'h94, 64'h0,  64'h04},              // R2 A&-A
        '{5'd10, 64'h94, 64'h0,  64'h03},              // R3 ~A&(A-1)
        '{5'd13, 64'h94, 64'h0,  64'h94},              // R2 A&(A+1)
        '{5'd7,  64'h94, 64'h0,  64'hFFFF_FFFF_FFFF_FFFE}, // R2 A|~(A+1)
        '{5'd3,  64'h0,  64'h0,  ONES},                // R5 0-1 wraps
        '{5'd21, ONES,   64'h0,  ONES},                // R5 ones+1 wraps
        '{5'd3,  64'hF0, 64'h0F, ONES}                 // R4 mask to zero
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [4:0]  in_mode;
    logic [63:0] in_ra;
    logic [63:0] in_rb;
    logic        out_valid;
    logic [63:0] out_result;

    int checks;
    int failures;
    bit done;

    lsb_mask_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_mode    (in_mode),
        .in_ra      (in_ra),
        .in_rb      (in_rb),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [63:0] model(logic [4:0] m, logic [63:0] ra, logic [63:0] rb);
        logic [63:0] a;
        logic [63:0] x;
        logic [63:0] y;
        a = (rb == 64'h0) ? ra : (ra & rb);
        x = m[0] ? a : ~a;
        case (m[2:1])
            2'd0:    y = 64'h0 - a;
            2'd1:    y = a - 64'h1;
            2'd2:    y = a + 64'h1;
            default: y = ~(a + 64'h1);
        endcase
        case (m[4:3])
            2'd0:    return x | y;
            2'd1:    return x & y;
            2'd2:    return x ^ y;
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one issue mid-cycle, check just after the next edge
    task automatic run_op(string req, logic [4:0] m, logic [63:0] ra, logic [63:0] rb,
                          logic [63:0] exp);
        in_valid = 1'b1;
        in_mode  = m;
        in_ra    = ra;
        in_rb    = rb;
        @(posedge clk);
        #1;
        check({req, " out_valid"}, {63'h0, out_valid}, 64'h1);
        check(req, out_result, exp);
    endtask

    initial begin
        done     = 1'b0;
        checks   = 0;
        failures = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_mode  = 5'd0;
        in_ra    = 64'h0;
        in_rb    = 64'h0;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 reset out_valid", {63'h0, out_valid}, 64'h0);
        check("R8 reset out_result", out_result, 64'h0);
        check("R8 reset in_ready", {63'h0, in_ready}, 64'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R8 ready after reset", {63'h0, in_ready}, 64'h1);

        // table of directed vectors, issued back to back (R6)
        for (int i = 0; i < NVEC; i++) begin
            run_op($sformatf("R6 table vector %0d", i), VECS[i].mode, VECS[i].ra,
                   VECS[i].rb, VECS[i].exp);
        end

        // R7: idle cycles keep the result and drop valid
        in_valid = 1'b0;
        in_mode  = 5'd19;
        in_ra    = 64'h1234;
        @(posedge clk);
        #1;
        check("R7 idle out_valid", {63'h0, out_valid}, 64'h0);
        check("R7 idle hold", out_result, VECS[NVEC-1].exp);
        @(posedge clk);
        #1;
        check("R7 second idle hold", out_result, VECS[NVEC-1].exp);

        // R5: negation of zero stays zero, A=0 with ~A first term
        run_op("R5 -0", 5'd1, 64'h0, 64'h0, 64'h0);
        run_op("R3 ~0 and ~(0+1)", 5'd14, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE);

        // sweep all 32 modes: R1 R2 R3 R4 R5
        for (int m = 0; m < 32; m++) begin
            for (int k = 0; k < 6; k++) begin
                logic [63:0] ra;
                logic [63:0] rb;
                ra = {$urandom(), $urandom()};
                rb = {$urandom(), $urandom()};
                if (k == 0) rb = 64'h0;
                if (k == 1) ra = 64'h0;
                if (k == 2) ra = ONES;
                if (k == 3) begin ra = ONES; rb = 64'h0; end
                run_op($sformatf("R1 R2 R3 R4 sweep mode %0d case %0d", m, k),
                       5'(m), ra, rb, model(5'(m), ra, rb));
            end
        end

        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R7 final idle out_valid", {63'h0, out_valid}, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule